// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block sits between the peripherals of a DMA controller and its transfer engine. Each channel has two hardware request lines: one asks for a single transfer and one asks for a burst. There is also a software request vector. The block combines these with per-channel control vectors from the register bank: enable, request mask, burst-only, high priority, wait-on-request and a rate exponent R. From the result it picks one channel and offers it to the transfer engine. The offer says whether the engine should move 2^R items (a burst) or one item (a single).

The grant is a valid/ready stream towards the engine. While `grant_valid` is high and `grant_ready` is low, the offered channel, kind and count stay frozen, so the engine can apply back-pressure for as long as it needs. Once the engine accepts the grant, the block does not arbitrate again until the engine pulses `xfer_done`.

A channel whose wait-on-request bit is set keeps the arbiter in a hold state after `xfer_done`. The hold lasts until that channel's hardware request lines are both low. This lets a slow or asynchronous requester take back its request before it could be served a second time.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, `grant_valid` is 0 and no grant is offered until a qualified request appears.
- R2: A channel is considered only while `master_en` is 1 and its `chan_en` bit is 1. With either at 0, none of its requests produces a grant.
- R3: A channel whose `req_mask` bit is 1 ignores its `single_req` and `burst_req` inputs.
- R4: A channel whose `burst_only` bit is 1 never gets a grant from `single_req`; it is still granted from `burst_req`.
- R5: A grant from a burst request has `grant_burst`=1 and `grant_count`=2^R, where R is the channel's 3-bit field `rate[3*ch+2:3*ch]`. A grant from a single request alone has `grant_burst`=0 and `grant_count`=1. When both hardware lines of the winning channel are high, the grant is a burst.
- R6: A one-cycle pulse on `sw_req[ch]` makes channel ch pending. The pending state survives until that channel's grant is accepted, including any time the channel spends disabled. The request mask does not affect it, and it is granted as a burst of 2^R.
- R7: Any qualified channel with `hi_prio` set wins over all qualified channels at the default level.
- R8: Within one priority level, the lowest-numbered qualified channel wins.
- R9: While `grant_valid`=1 and `grant_ready`=0, `grant_valid`, `grant_ch`, `grant_burst` and `grant_count` hold their values.
- R10: After a grant is accepted, `grant_valid` stays 0 until `xfer_done` has been seen. The next grant appears no earlier than the second clock edge after `xfer_done`.
- R11: If the served channel has `wait_req` set and its `single_req` or `burst_req` is still high at `xfer_done`, no grant is offered until both lines are low. Without `wait_req`, the channel may be granted again while its request is still high.
- R12: Timing: a request that qualifies at a clock edge while the arbiter is idle is offered on the `grant_*` outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| master_en | input | 1 | Global enable for all channels |
| chan_en | input | NCH | Per-channel enable |
| req_mask | input | NCH | Per-channel hardware request mask |
| burst_only | input | NCH | Per-channel: ignore single requests |
| hi_prio | input | NCH | Per-channel high priority |
| wait_req | input | NCH | Per-channel wait-on-request hold |
| rate | input | NCH*RW | Packed per-channel burst exponent R |
| single_req | input | NCH | Peripheral single-transfer request lines |
| burst_req | input | NCH | Peripheral burst request lines |
| sw_req | input | NCH | Software request pulses |
| grant_valid | output | 1 | Grant offered to the engine |
| grant_ready | input | 1 | Engine accepts the offered grant |
| grant_ch | output | $clog2(NCH) | Granted channel number |
| grant_burst | output | 1 | 1 for a burst grant, 0 for a single |
| grant_count | output | 2**RW | Number of transfers to perform |
| xfer_done | input | 1 | Engine finished the accepted grant |

## Verification
A table of request patterns tests the qualification and the pick. The patterns are: one line alone per channel; single and burst requests on the same channel; two requesters at the same level; a high-priority channel against a lower-numbered default one; a masked, disabled or burst-only channel beside a live one; and software pulses on a masked channel. Together these separate the mask, the enable gates, the burst-only filter, the priority order and the count encoding from one another. Directed sequences hold a grant under back-pressure and withhold `xfer_done` while a rival waits. They also keep the served request high at completion, with and without `wait_req`, which tells the hold apart from plain re-arbitration. A software pulse sent to a disabled channel shows that the pending state survives until the channel is enabled.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_BUSY  = 2'd2,
    ST_HOLD  = 2'd3
  } arb_state_t;
endpackage

// File: rtl/dma_sw_pending.sv
module dma_sw_pending #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] sw_req,
  input  logic [NCH-1:0] clr,
  output logic [NCH-1:0] pend
);
  logic [NCH-1:0] pend_q;

  // a pulse counts in the same cycle it arrives
  assign pend = pend_q | sw_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend & ~clr;
  end

  // R6: an accepted software request is dropped on the next edge
  a_r6_pend_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr & ~sw_req)) |=> ((pend_q & $past(clr & ~sw_req)) == '0));
endmodule

// File: rtl/dma_req_qualify.sv
module dma_req_qualify #(
  parameter int NCH = 8
) (
  input  logic           master_en,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] req_mask,
  input  logic [NCH-1:0] burst_only,
  input  logic [NCH-1:0] single_req,
  input  logic [NCH-1:0] burst_req,
  input  logic [NCH-1:0] sw_pend,
  output logic [NCH-1:0] elig,
  output logic [NCH-1:0] is_burst
);
  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      logic hw_burst;
      logic hw_single;
      assign hw_burst    = ~req_mask[g] & burst_req[g];
      assign hw_single   = ~req_mask[g] & single_req[g] & ~burst_only[g];
      assign elig[g]     = master_en & chan_en[g] & (sw_pend[g] | hw_burst | hw_single);
      assign is_burst[g] = sw_pend[g] | hw_burst;
    end
  endgenerate
endmodule

// File: rtl/dma_pick.sv
module dma_pick #(
  parameter int NCH = 8,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] elig,
  input  logic [NCH-1:0] hi_prio,
  output logic [NCH-1:0] win,
  output logic [IW-1:0]  win_idx,
  output logic           any
);
  logic [NCH-1:0] hi_set;
  logic [NCH-1:0] pool;

  assign hi_set = elig & hi_prio;
  assign pool   = (|hi_set) ? hi_set : elig;
  assign win    = pool & (~pool + 1'b1);
  assign any    = |elig;

  always_comb begin
    win_idx = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (win[i]) win_idx = IW'(i);
    end
  end
endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 8,
  parameter int RW  = 3,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CW = 2 ** RW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_en,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH-1:0]    req_mask,
  input  logic [NCH-1:0]    burst_only,
  input  logic [NCH-1:0]    hi_prio,
  input  logic [NCH-1:0]    wait_req,
  input  logic [NCH*RW-1:0] rate,
  input  logic [NCH-1:0]    single_req,
  input  logic [NCH-1:0]    burst_req,
  input  logic [NCH-1:0]    sw_req,
  output logic              grant_valid,
  input  logic              grant_ready,
  output logic [IW-1:0]     grant_ch,
  output logic              grant_burst,
  output logic [CW-1:0]     grant_count,
  input  logic              xfer_done
);
  arb_state_t     state;
  logic [NCH-1:0] sw_pend;
  logic [NCH-1:0] sw_clr;
  logic [NCH-1:0] elig;
  logic [NCH-1:0] is_burst;
  logic [NCH-1:0] win;
  logic [IW-1:0]  win_idx;
  logic           any;
  logic [RW-1:0]  win_rate;
  logic           served_req;
  logic           accept;

  assign accept      = (state == ST_OFFER) && grant_ready;
  assign grant_valid = (state == ST_OFFER);
  assign sw_clr      = accept ? (NCH'(1) << grant_ch) : '0;
  assign win_rate    = rate[win_idx*RW +: RW];
  assign served_req  = single_req[grant_ch] | burst_req[grant_ch];

  dma_sw_pending #(.NCH(NCH)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .sw_req(sw_req),
    .clr   (sw_clr),
    .pend  (sw_pend)
  );

  dma_req_qualify #(.NCH(NCH)) u_qual (
    .master_en (master_en),
    .chan_en   (chan_en),
    .req_mask  (req_mask),
    .burst_only(burst_only),
    .single_req(single_req),
    .burst_req (burst_req),
    .sw_pend   (sw_pend),
    .elig      (elig),
    .is_burst  (is_burst)
  );

  dma_pick #(.NCH(NCH)) u_pick (
    .elig   (elig),
    .hi_prio(hi_prio),
    .win    (win),
    .win_idx(win_idx),
    .any    (any)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      grant_ch    <= '0;
      grant_burst <= 1'b0;
      grant_count <= '0;
    end else begin
      case (state)
        ST_IDLE: if (any) begin
          grant_ch    <= win_idx;
          grant_burst <= is_burst[win_idx];
          grant_count <= is_burst[win_idx] ? (CW'(1) << win_rate) : CW'(1);
          state       <= ST_OFFER;
        end
        ST_OFFER: if (grant_ready) state <= ST_BUSY;
        ST_BUSY: if (xfer_done) begin
          state <= (wait_req[grant_ch] && served_req) ? ST_HOLD : ST_IDLE;
        end
        ST_HOLD: if (!served_req) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R9: offer frozen under back-pressure
  a_r9_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=> (grant_valid && $stable(grant_ch) &&
      $stable(grant_burst) && $stable(grant_count)));

  // R10: nothing offered while the engine is working
  a_r10_no_regrant: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY && !xfer_done) |=> !grant_valid);

  // R11: hold blocks the arbiter while the served request is high
  a_r11_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD && served_req) |=> !grant_valid);

  // R5: a single grant moves exactly one item
  a_r5_single_count: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_burst) |-> (grant_count == CW'(1)));

  // R7: a qualified high-priority channel is always the winner
  a_r7_prio_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && |(elig & hi_prio)) |-> ((win & hi_prio) != '0));

  // R8: the picked channel is one of the qualified ones
  a_r8_win_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ($onehot0(win) && ((win & elig) != '0)));
endmodule

// File: tb/tb_dma_req_arbiter.sv
module tb_dma_req_arbiter;
  localparam int NCH = 8;
  localparam int RW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_en = 1'b0;
  logic [NCH-1:0] chan_en = '0, req_mask = '0, burst_only = '0, hi_prio = '0, wait_req = '0;
  logic [NCH*RW-1:0] rate;
  logic [NCH-1:0] single_req = '0, burst_req = '0, sw_req = '0;
  logic grant_valid, grant_ready = 1'b0, grant_burst, xfer_done = 1'b0;
  logic [2:0] grant_ch;
  logic [7:0] grant_count;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dma_req_arbiter #(.NCH(NCH), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .chan_en(chan_en),
    .req_mask(req_mask), .burst_only(burst_only), .hi_prio(hi_prio),
    .wait_req(wait_req), .rate(rate), .single_req(single_req),
    .burst_req(burst_req), .sw_req(sw_req), .grant_valid(grant_valid),
    .grant_ready(grant_ready), .grant_ch(grant_ch), .grant_burst(grant_burst),
    .grant_count(grant_count), .xfer_done(xfer_done)
  );

  typedef struct packed {
    logic       men;
    logic [7:0] en, mask, bo, hi, sreq, breq, sw;
    logic       ev;
    logic [2:0] ech;
    logic       eb;
    logic [7:0] ecnt;
  } vec_t;

  // rate of channel i is i, so a burst on channel i moves 2^i items
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 1'b1, 3'd0, 1'b1, 8'd1},   // R5 burst R=0
    '{1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 8'h00, 1'b1, 3'd3, 1'b0, 8'd1},   // R5 single
    '{1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00, 8'h08, 8'h00, 1'b1, 3'd3, 1'b1, 8'd8},   // R5 burst
    '{1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h24, 8'h00, 8'h00, 1'b1, 3'd2, 1'b0, 8'd1},   // R8
    '{1'b1, 8'hFF, 8'h00, 8'h00, 8'h80, 8'h00, 8'h81, 8'h00, 1'b1, 3'd7, 1'b1, 8'd128}, // R7
    '{1'b1, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 1'b1, 3'd1, 1'b1, 8'd2},   // R3
    '{1'b1, 8'hFF, 8'h10, 8'h00, 8'h00, 8'h10, 8'h10, 8'h00, 1'b0, 3'd0, 1'b0, 8'd0},   // R3 none
    '{1'b1, 8'hFF, 8'h00, 8'h20, 8'h00, 8'h20, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'd0},   // R4 none
    '{1'b1, 8'hFF, 8'h00, 8'h20, 8'h00, 8'h00, 8'h20, 8'h00, 1'b1, 3'd5, 1'b1, 8'd32},  // R4 burst ok
    '{1'b1, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00, 8'h03, 8'h00, 1'b1, 3'd1, 1'b1, 8'd2},   // R2 chan off
    '{1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 1'b0, 3'd0, 1'b0, 8'd0},   // R2 master off
    '{1'b1, 8'hFF, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h40, 1'b1, 3'd6, 1'b1, 8'd64},  // R6 sw masked
    '{1'b1, 8'hFF, 8'h00, 8'h00, 8'h02, 8'h01, 8'h02, 8'h00, 1'b1, 3'd1, 1'b1, 8'd2},   // R7
    '{1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h10, 8'h10, 8'h00, 1'b1, 3'd4, 1'b1, 8'd16},  // R5 both lines
    '{1'b1, 8'hFF, 8'h00, 8'h00, 8'h18, 8'h00, 8'h18, 8'h00, 1'b1, 3'd3, 1'b1, 8'd8}    // R8 in high level
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_grant(input string req, input logic [2:0] ch, input logic b, input logic [7:0] cnt);
    chk(grant_valid === 1'b1, req, grant_valid, 1);
    chk(grant_ch === ch, req, grant_ch, ch);
    chk(grant_burst === b, req, grant_burst, b);
    chk(grant_count === cnt, req, grant_count, cnt);
  endtask

  // accept at this negedge, then complete with requests cleared
  task automatic finish_grant();
    grant_ready = 1'b1;
    @(negedge clk);
    grant_ready = 1'b0;
    single_req = '0; burst_req = '0;
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NCH; i++) rate[i*RW +: RW] = RW'(i);
    repeat (3) @(negedge clk);
    chk(grant_valid === 1'b0, "R1", grant_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(grant_valid === 1'b0, "R1", grant_valid, 0);

    // table walk: each vector applied at a negedge, result checked one edge later (R12)
    for (int v = 0; v < NV; v++) begin
      master_en = VEC[v].men; chan_en = VEC[v].en; req_mask = VEC[v].mask;
      burst_only = VEC[v].bo; hi_prio = VEC[v].hi; single_req = VEC[v].sreq;
      burst_req = VEC[v].breq; sw_req = VEC[v].sw;
      @(negedge clk);
      sw_req = '0;
      if (VEC[v].ev) begin
        chk_grant("R12 table", VEC[v].ech, VEC[v].eb, VEC[v].ecnt);
        @(negedge clk);
        chk_grant("R9 held", VEC[v].ech, VEC[v].eb, VEC[v].ecnt);
        finish_grant();
      end else begin
        chk(grant_valid === 1'b0, "R2/R3/R4 no grant", grant_valid, 0);
        single_req = '0; burst_req = '0;
        @(negedge clk);
      end
    end
    master_en = 1'b1; chan_en = 8'hFF; req_mask = '0; burst_only = '0; hi_prio = '0;

    // R10: no regrant before xfer_done
    burst_req = 8'h01;
    @(negedge clk);
    chk_grant("R10 first", 3'd0, 1'b1, 8'd1);
    grant_ready = 1'b1;
    @(negedge clk);
    grant_ready = 1'b0;
    burst_req = 8'h02;
    repeat (3) begin
      @(negedge clk);
      chk(grant_valid === 1'b0, "R10 busy", grant_valid, 0);
    end
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(grant_valid === 1'b0, "R10 gap", grant_valid, 0);
    @(negedge clk);
    chk_grant("R10 next", 3'd1, 1'b1, 8'd2);
    finish_grant();

    // R11: wait-on-request hold
    wait_req = 8'h04; burst_req = 8'h0C;
    @(negedge clk);
    chk_grant("R11 pick", 3'd2, 1'b1, 8'd4);
    grant_ready = 1'b1;
    @(negedge clk);
    grant_ready = 1'b0; xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(grant_valid === 1'b0, "R11 hold", grant_valid, 0);
    end
    burst_req = 8'h08;
    @(negedge clk);
    chk(grant_valid === 1'b0, "R11 release", grant_valid, 0);
    @(negedge clk);
    chk_grant("R11 after", 3'd3, 1'b1, 8'd8);
    finish_grant();
    wait_req = '0;

    // R11: without the bit the same channel is served again
    burst_req = 8'h04;
    @(negedge clk);
    chk_grant("R11 nowait", 3'd2, 1'b1, 8'd4);
    grant_ready = 1'b1;
    @(negedge clk);
    grant_ready = 1'b0; xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
    chk(grant_valid === 1'b0, "R11 nowait gap", grant_valid, 0);
    @(negedge clk);
    chk_grant("R11 regrant", 3'd2, 1'b1, 8'd4);
    finish_grant();

    // R6: pending survives a disabled channel
    chan_en = 8'hBF; sw_req = 8'h40;
    @(negedge clk);
    sw_req = '0;
    repeat (4) begin
      chk(grant_valid === 1'b0, "R6 disabled", grant_valid, 0);
      @(negedge clk);
    end
    chan_en = 8'hFF;
    @(negedge clk);
    chk_grant("R6 pending", 3'd6, 1'b1, 8'd64);
    finish_grant();
    @(negedge clk);
    chk(grant_valid === 1'b0, "R6 cleared", grant_valid, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule